// File: doc/BRIEF.md
# Synchronous Burst SRAM Core with Selectable Read Latency

This block is a small synthesizable static RAM for simulation and on-chip use. All commands are taken on the rising clock edge: an address, two chip enables, per-lane byte writes and an all-lane global write. Reads come out on a separate read bus with a drive-enable flag. A static mode input chooses how reads leave the core. In flow-through mode the array output goes straight to the bus. In pipelined mode it passes through one more output register, which adds a clock of latency.

Output turn-off follows single-cycle-deselect timing. A deselect clears the drive flag right after the edge that captures it, even when a pipelined read beat is still in the output register. An asynchronous output enable and an asynchronous sleep input also gate the drive. Sleep additionally blocks every command, and the array contents are kept while it is high.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is asserted and after its release, with no read issued, `rdrive` is 0 and `rdata` is all zeros.
- R2: With `pipe_mode`=0 (flow-through), a read captured at clock edge k drives `rdrive`=1 and `rdata`=mem[addr] in the cycle after edge k. Counting the address cycle as the first, the data arrives in cycle 2.
- R3: With `pipe_mode`=1 (pipelined), a read captured at edge k drives its data only after edge k+1. Counting the address cycle as the first, the data arrives in cycle 3. After edge k, the output still reflects the previous command.
- R4: Reads issued back to back on consecutive edges produce one new data word per cycle in both modes.
- R5: A cycle is deselected when `en_a` and `en_b` are not both 1. The edge that captures a deselect clears `rdrive` and zeroes `rdata` right after that edge. This applies in pipelined mode as well, even though a read beat is still held in the output register.
- R6: With `gwe`=0 and `bwe`=1, lane i (bits i*LW+LW-1 down to i*LW) is written only where `bsel[i]`=1. The other lanes keep their contents. If `bsel` is all zeros, or if `bwe`=0, the selected cycle is a read and nothing is written.
- R7: With `gwe`=1, all lanes of the addressed word are written, whatever `bwe` and `bsel` are.
- R8: A write completes at the edge that captures it. A read of the same address captured on the next edge returns the new data.
- R9: `oe` gates `rdrive` combinationally, with no clock edge needed. Whenever `rdrive` is 0, `rdata` is all zeros.
- R10: While `sleep`=1, `rdrive` is forced to 0 at once. Commands captured during sleep neither write nor read, and the stored data is unchanged after sleep is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control registers |
| addr | input | AW | Word address |
| en_a | input | 1 | Chip enable A (active high) |
| en_b | input | 1 | Chip enable B (active high) |
| bwe | input | 1 | Byte-write enable |
| bsel | input | NB | Per-lane write selects |
| gwe | input | 1 | Global write, all lanes |
| wdata | input | DW | Write data |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep request |
| pipe_mode | input | 1 | 0 flow-through, 1 pipelined reads |
| rdata | output | DW | Read data, zero when not driven |
| rdrive | output | 1 | Read bus drive enable |

## Verification
In flow-through mode, a read's word is due one edge after its capture edge. In pipelined mode it is due two edges after, and the pipelined checks always look one command behind the read just issued. A deselect or a sleep must take effect right after the first edge that captures it. `oe` and `sleep` must take effect without any edge at all. The bench drives inputs on the falling edge and samples 1 ns after each rising edge, so every comparison sees the state left by exactly the edge under test. The asynchronous checks are sampled a few nanoseconds after the input changes, mid-cycle, with no edge in between.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          en_a,
  input  logic          en_b,
  input  logic          bwe,
  input  logic [NB-1:0] bsel,
  input  logic          gwe,
  input  logic [DW-1:0] wdata,
  input  logic          oe,
  input  logic          sleep,
  input  logic          pipe_mode,
  output logic [DW-1:0] rdata,
  output logic          rdrive
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] a_q;
  logic [DW-1:0] dout_q;
  logic          rd_q, rd_p, desel_q;

  wire          sel    = en_a & en_b;
  wire [NB-1:0] lanes  = gwe ? {NB{1'b1}} : (bwe ? bsel : {NB{1'b0}});
  wire          wr_cmd = sel & (|lanes);
  wire          rd_cmd = sel & ~(|lanes);

  always_ff @(posedge clk) begin
    if (!sleep && wr_cmd)
      for (int i = 0; i < NB; i++)
        if (lanes[i]) mem[addr][i*LW +: LW] <= wdata[i*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      dout_q  <= '0;
      rd_q    <= 1'b0;
      rd_p    <= 1'b0;
      desel_q <= 1'b1;
    end else begin
      rd_q    <= rd_cmd & ~sleep;
      desel_q <= sleep | ~sel;
      rd_p    <= rd_q;
      if (rd_cmd && !sleep) a_q <= addr;
      if (rd_q) dout_q <= mem[a_q];
    end
  end

  wire          valid = pipe_mode ? rd_p : rd_q;
  wire [DW-1:0] data  = pipe_mode ? dout_q : mem[a_q];

  assign rdrive = oe & ~sleep & valid & ~desel_q;
  assign rdata  = rdrive ? data : '0;

  p_scd_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel) |=> !rdrive);

  p_flow_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && rd_cmd && !pipe_mode) |=> (pipe_mode || !oe || sleep || rdrive));

  p_pipe_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && rd_cmd && pipe_mode) ##1 (!sleep && sel) |=> (!pipe_mode || !oe || sleep || rdrive));

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rdrive);

  p_gw_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && sel && gwe) |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int AW = 4, NB = 4, LW = 8, DW = 32, DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic en_a = 0, en_b = 0, bwe = 0, gwe = 0, oe = 1, sleep = 0, pipe_mode = 0;
  logic [NB-1:0] bsel = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdrive;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] exp_m [DEPTH];

  always #5 clk = ~clk;

  sync_burst_sram #(.AW(AW), .NB(NB), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en_a(en_a), .en_b(en_b),
    .bwe(bwe), .bsel(bsel), .gwe(gwe), .wdata(wdata), .oe(oe),
    .sleep(sleep), .pipe_mode(pipe_mode), .rdata(rdata), .rdrive(rdrive));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic chk_out(input string req, input logic d, input logic [DW-1:0] v);
    chk({req, " drive"}, {31'b0, rdrive}, {31'b0, d});
    chk({req, " data"}, rdata, d ? v : '0);
  endtask

  task automatic cmd(input logic ea, input logic eb, input logic gw, input logic bw,
                     input logic [NB-1:0] bs, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    en_a = ea; en_b = eb; gwe = gw; bwe = bw; bsel = bs; addr = a; wdata = d;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    cmd(1, 1, 0, 0, '0, a, '0);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(posedge clk);
    #1 chk_out("R1 in reset", 0, '0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1 chk_out("R1 after reset", 0, '0);

    for (int a = 0; a < DEPTH; a++) begin
      exp_m[a] = (32'h01010101 * a) ^ 32'h3C5A96E1;
      cmd(1, 1, 1, 0, '0, a[AW-1:0], exp_m[a]);
    end
    for (int a = 0; a < DEPTH; a++) begin
      rd(a[AW-1:0]);
      chk_out("R2 R4 flow read", 1, exp_m[a]);
    end

    for (int a = 0; a < DEPTH; a++) begin
      d = ~exp_m[a] ^ (32'h00000100 * a);
      cmd(1, 1, 0, 1, a[NB-1:0], a[AW-1:0], d);
      if (a == 0) chk_out("R6 empty bsel reads", 1, exp_m[0]);
      for (int i = 0; i < NB; i++)
        if (a[i]) exp_m[a][i*LW +: LW] = d[i*LW +: LW];
    end
    for (int a = 0; a < DEPTH; a++) begin
      rd(a[AW-1:0]);
      chk_out("R6 lane readback", 1, exp_m[a]);
    end
    cmd(1, 1, 0, 0, 4'hF, 4'd7, 32'hDEADBEEF);
    rd(4'd7); chk_out("R6 bwe low no write", 1, exp_m[7]);

    exp_m[9] = 32'h12345678;
    cmd(1, 1, 1, 1, 4'b0001, 4'd9, exp_m[9]);
    rd(4'd9); chk_out("R7 global over bsel", 1, exp_m[9]);
    exp_m[10] = 32'hCAFEF00D;
    cmd(1, 1, 1, 0, 4'b0000, 4'd10, exp_m[10]);
    rd(4'd10); chk_out("R7 global no bwe", 1, exp_m[10]);

    exp_m[12] = 32'h0BADC0DE;
    cmd(1, 1, 1, 0, '0, 4'd12, exp_m[12]);
    rd(4'd12); chk_out("R8 read after write", 1, exp_m[12]);

    rd(4'd2); chk_out("R5 flow pre", 1, exp_m[2]);
    cmd(1, 0, 0, 0, '0, 4'd2, '0);
    chk_out("R5 flow deselect", 0, '0);

    #1 pipe_mode = 1;
    cmd(0, 1, 0, 0, '0, 0, '0);
    rd(4'd0); chk_out("R3 not yet", 0, '0);
    for (int a = 1; a < DEPTH; a++) begin
      rd(a[AW-1:0]);
      chk_out("R3 R4 pipe read", 1, exp_m[a-1]);
    end
    cmd(0, 0, 0, 0, '0, 0, '0);
    chk_out("R5 pipe deselect", 0, '0);

    rd(4'd4); chk_out("R3 first beat pending", 0, '0);
    rd(4'd5); chk_out("R3 pipe after idle", 1, exp_m[4]);

    #2 oe = 0;
    #1 chk_out("R9 oe low", 0, '0);
    oe = 1;
    #1 chk_out("R9 oe high", 1, exp_m[4]);

    sleep = 1;
    #1 chk_out("R10 sleep immediate", 0, '0);
    cmd(1, 1, 1, 0, '0, 4'd4, 32'hFFFF0000);
    chk_out("R10 sleep write", 0, '0);
    rd(4'd4); chk_out("R10 sleep read", 0, '0);
    @(negedge clk) sleep = 0;
    rd(4'd4);
    rd(4'd4); chk_out("R10 contents kept", 1, exp_m[4]);

    done = 1;
    finish_run();
  end
endmodule